// File: doc/BRIEF.md
# Four-Bank GPIO Controller with Masked Half-Word Writes

This block is a register-mapped general-purpose I/O controller. It serves four banks of 32 pins each, and bank 1 implements only its low 22 pins. A plain 32-bit register port reaches every register. That port has a byte address, a write strobe, write data and a combinational read-data return. For each pin the block drives an output value and a tristate drive enable, and it samples an input level.

Software can write the output latch of a bank as a whole word. It can also write one 16-bit half of that latch through a masked-write register. In such a write, the upper half of the write word selects which bits keep their old value. Single pins can therefore be set or cleared atomically, with no read-modify-write.

Each bank also has interrupt logic. Inputs are synchronized through two flops. Each pin can then be detected as a rising, falling or either edge, or as a high or low level. Detected events latch into sticky status bits. The interrupt line is raised for any status bit whose mask is cleared.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Bank 1 implements pins 0..21 only. Its bits 22..31 read as 0 in every register of that bank and ignore writes. Banks 0, 2 and 3 implement all 32 bits.
- R2: A write to offset 8*b updates bank b output bits 15:0, and a write to offset 8*b+4 updates bits 31:16. Write bits 31:16 are the keep-mask and bits 15:0 are the data. An output bit takes the data bit where its mask bit is 0 and holds its value where its mask bit is 1.
- R3: Offset 0x40+4*b is the bank b output register. A write replaces all implemented bits and a read returns the register.
- R4: Offset 0x60+4*b is read-only and returns the pin inputs through a two-flop synchronizer. An input change made before one clock edge is visible to a read after the second edge and not after the first.
- R5: The control registers of bank b sit at 0x204+0x40*b with a 4-byte step, in this order: direction, output enable, interrupt mask, interrupt enable, interrupt disable, interrupt status, interrupt type, interrupt polarity, interrupt any-edge.
- R6: The pin output equals the output register bit. The drive enable is 1 only where both the direction bit and the output-enable bit are 1.
- R7: After reset, the output, direction, output-enable, polarity and any-edge registers are 0. The type register is 1 for every implemented bit. The mask register is 1 for every implemented bit. The interrupt line is 0.
- R8: Writing 1 to an interrupt-enable bit clears the mask bit, and writing 1 to an interrupt-disable bit sets it. Zero bits do nothing. The mask reads back its current value, and the enable and disable offsets read as 0.
- R9: A status bit sets when its event is detected, whether or not it is masked. Writing 1 to the bit clears it and writing 0 leaves it. An event in the same cycle as a clear leaves the bit set.
- R10: With type 1, a pin is edge-triggered. Any-edge 1 catches both edges. Otherwise polarity 1 selects a 0-to-1 change and polarity 0 selects a 1-to-0 change. With type 0, a pin is level-triggered: polarity 1 selects a high level and polarity 0 selects a low level.
- R11: The interrupt output is 1 exactly when some bank has a status bit set whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |
| pin_in | input | 128 | Pin input levels, 32 per bank |
| pin_out | output | 128 | Pin output values |
| pin_oe | output | 128 | Pin drive enables (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
The table of masked writes mixes full masks, empty masks and partial masks in both halves. A design that swapped the sense of the mask, or wrote the wrong half, would read back a wrong output word. Writes of all ones to bank 1 check that its upper ten bits stay 0; a design that ignored the narrow bank would show them set. The input register is read after one edge and after two edges, so a missing or extra synchronizer stage shows up as an early or late value. The interrupt tests walk falling, rising, any-edge and level detection. They include a clear issued while a level event persists, which a design that gave the clear priority would read back as 0.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NB         = 4,
  parameter int W          = 32,
  parameter int AW         = 12,
  parameter int SHORT_BANK = 1,
  parameter int SHORT_PINS = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [W-1:0]    wr_data,
  output logic [W-1:0]    rd_data,
  input  logic [NB*W-1:0] pin_in,
  output logic [NB*W-1:0] pin_out,
  output logic [NB*W-1:0] pin_oe,
  output logic            irq
);
  localparam int PINS = NB * W;
  localparam int HW   = W / 2;

  function automatic logic [W-1:0] impl(input int b);
    if (b == SHORT_BANK) return W'((64'd1 << SHORT_PINS) - 64'd1);
    return '1;
  endfunction

  function automatic logic [AW-1:0] ctl(input int b, input int k);
    return AW'(32'h204 + 32'h40 * b + 4 * k);
  endfunction

  logic [W-1:0] dout [NB];
  logic [W-1:0] dir  [NB];
  logic [W-1:0] oen  [NB];
  logic [W-1:0] msk  [NB];
  logic [W-1:0] stat [NB];
  logic [W-1:0] typ  [NB];
  logic [W-1:0] pol  [NB];
  logic [W-1:0] anye [NB];
  logic [W-1:0] ev   [NB];
  logic [PINS-1:0] s1, s2, s3;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      logic [W-1:0] lv, rise, fall, edg;
      lv   = s2[b*W +: W];
      rise = lv & ~s3[b*W +: W];
      fall = ~lv & s3[b*W +: W];
      edg  = (anye[b] & (rise | fall)) | (~anye[b] & ((pol[b] & rise) | (~pol[b] & fall)));
      ev[b] = impl(b) & ((typ[b] & edg) | (~typ[b] & ((pol[b] & lv) | (~pol[b] & ~lv))));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
      for (int b = 0; b < NB; b++) begin
        dout[b] <= '0;
        dir[b]  <= '0;
        oen[b]  <= '0;
        msk[b]  <= impl(b);
        stat[b] <= '0;
        typ[b]  <= impl(b);
        pol[b]  <= '0;
        anye[b] <= '0;
      end
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
      for (int b = 0; b < NB; b++) begin
        if (wr_en && addr == ctl(b, 5))
          stat[b] <= (stat[b] & ~wr_data) | ev[b];
        else
          stat[b] <= stat[b] | ev[b];
        if (wr_en) begin
          if (addr == AW'(8 * b))
            dout[b][HW-1:0] <= ((dout[b][HW-1:0] & wr_data[W-1:HW]) |
                                (wr_data[HW-1:0] & ~wr_data[W-1:HW])) & impl(b)[HW-1:0];
          if (addr == AW'(8 * b + 4))
            dout[b][W-1:HW] <= ((dout[b][W-1:HW] & wr_data[W-1:HW]) |
                                (wr_data[HW-1:0] & ~wr_data[W-1:HW])) & impl(b)[W-1:HW];
          if (addr == AW'(32'h40 + 4 * b)) dout[b] <= wr_data & impl(b);
          if (addr == ctl(b, 0)) dir[b]  <= wr_data & impl(b);
          if (addr == ctl(b, 1)) oen[b]  <= wr_data & impl(b);
          if (addr == ctl(b, 3)) msk[b]  <= msk[b] & ~wr_data;
          if (addr == ctl(b, 4)) msk[b]  <= msk[b] | (wr_data & impl(b));
          if (addr == ctl(b, 6)) typ[b]  <= wr_data & impl(b);
          if (addr == ctl(b, 7)) pol[b]  <= wr_data & impl(b);
          if (addr == ctl(b, 8)) anye[b] <= wr_data & impl(b);
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NB; b++) begin
      if (addr == AW'(32'h40 + 4 * b)) rd_data = dout[b];
      if (addr == AW'(32'h60 + 4 * b)) rd_data = s2[b*W +: W] & impl(b);
      if (addr == ctl(b, 0)) rd_data = dir[b];
      if (addr == ctl(b, 1)) rd_data = oen[b];
      if (addr == ctl(b, 2)) rd_data = msk[b];
      if (addr == ctl(b, 5)) rd_data = stat[b];
      if (addr == ctl(b, 6)) rd_data = typ[b];
      if (addr == ctl(b, 7)) rd_data = pol[b];
      if (addr == ctl(b, 8)) rd_data = anye[b];
    end
  end

  always_comb begin
    irq = 1'b0;
    for (int b = 0; b < NB; b++) irq = irq | (|(stat[b] & ~msk[b]));
  end

  for (genvar g = 0; g < NB; g++) begin : g_pins
    assign pin_out[g*W +: W] = dout[g];
    assign pin_oe[g*W +: W]  = dir[g] & oen[g];
  end

  p_masked_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(addr) == AW'(0)) |->
      ((dout[0][HW-1:0] & $past(wr_data[W-1:HW])) == ($past(dout[0][HW-1:0]) & $past(wr_data[W-1:HW]))));

  p_stat_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(wr_en) && $past(addr) == ctl(0, 5)) |-> ((stat[0] & $past(stat[0])) == $past(stat[0])));

  p_unimpl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dout[SHORT_BANK] & ~impl(SHORT_BANK)) == '0 && (msk[SHORT_BANK] & ~impl(SHORT_BANK)) == '0);

  p_drive_needs_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe[W-1:0] & ~dir[0]) == '0);

  p_unmasked_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat[0] & ~msk[0]) != '0) |-> irq);

  p_reset_quiet_r7: assert property (@(posedge clk)
    $rose(rst_n) |-> (pin_oe == '0 && !irq));
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [11:0]  addr = '0;
  logic         wr_en = 0;
  logic [31:0]  wr_data = '0;
  logic [31:0]  rd_data;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out, pin_oe;
  logic         irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  gpio_bank_ctrl dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
                      .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {write addr, write data, read addr, expected read}
  localparam logic [87:0] VEC [12] = '{
    {12'h040, 32'h0000_0000, 12'h040, 32'h0000_0000},  // R3
    {12'h000, 32'hFFFE_0001, 12'h040, 32'h0000_0001},  // R2 single pin set
    {12'h004, 32'h7FFF_8000, 12'h040, 32'h8000_0001},  // R2 high half pin 31
    {12'h000, 32'h0000_1234, 12'h040, 32'h8000_1234},  // R2 empty mask
    {12'h004, 32'hFF00_00AB, 12'h040, 32'h80AB_1234},  // R2 partial mask
    {12'h00C, 32'h0000_FFFF, 12'h044, 32'h003F_0000},  // R1 narrow bank high half
    {12'h044, 32'hFFFF_FFFF, 12'h044, 32'h003F_FFFF},  // R1 narrow bank full word
    {12'h048, 32'hDEAD_BEEF, 12'h048, 32'hDEAD_BEEF},  // R3 bank 2
    {12'h04C, 32'hFFFF_FFFF, 12'h04C, 32'hFFFF_FFFF},  // R3 bank 3
    {12'h01C, 32'hFFFE_0000, 12'h04C, 32'hFFFE_FFFF},  // R2 single pin clear
    {12'h244, 32'hFFFF_FFFF, 12'h244, 32'h003F_FFFF},  // R5 bank 1 direction, R1
    {12'h2C8, 32'h0000_FFFF, 12'h2C8, 32'h0000_FFFF}   // R5 bank 3 output enable
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R7 reset state
    rd(12'h040, v); chk("R7 output reg", v, 32'h0);
    rd(12'h20C, v); chk("R7 bank0 mask", v, 32'hFFFF_FFFF);
    rd(12'h24C, v); chk("R7 bank1 mask", v, 32'h003F_FFFF);
    rd(12'h21C, v); chk("R7 bank0 type", v, 32'hFFFF_FFFF);
    rd(12'h2A0, v); chk("R7 bank2 polarity", v, 32'h0);
    chk("R7 drive enables", {31'd0, |pin_oe}, 32'd0);
    chk("R7 irq", {31'd0, irq}, 32'd0);

    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][87:76], VEC[i][75:44]);
      rd(VEC[i][43:32], v);
      chk($sformatf("R2/R3 vector %0d", i), v, VEC[i][31:0]);
    end

    // R6 drive enable and output value
    wr(12'h2C4, 32'h00FF_00FF);
    cyc(1);
    chk("R6 bank3 oe", pin_oe[127:96], 32'h0000_00FF);
    chk("R6 bank3 out", pin_out[127:96], 32'hFFFE_FFFF);
    chk("R6 bank0 out", pin_out[31:0], 32'h80AB_1234);
    chk("R6 bank0 oe", pin_oe[31:0], 32'h0);

    // R4 synchronizer latency
    @(negedge clk);
    pin_in[31:0] = 32'hA5A5_A5A5;
    pin_in[63:32] = 32'hFFFF_FFFF;
    @(negedge clk);
    rd(12'h060, v); chk("R4 after one edge", v, 32'h0);
    @(negedge clk);
    rd(12'h060, v); chk("R4 after two edges", v, 32'hA5A5_A5A5);
    rd(12'h064, v); chk("R4 R1 narrow input", v, 32'h003F_FFFF);

    cyc(3);
    wr(12'h218, 32'hFFFF_FFFF);
    wr(12'h258, 32'hFFFF_FFFF);
    rd(12'h218, v); chk("R9 cleared", v, 32'h0);

    // R10 falling edge (default), R9 set while masked
    pin_in[0] = 0; cyc(4);
    rd(12'h218, v); chk("R10 falling edge status", v, 32'h1);
    chk("R11 masked no irq", {31'd0, irq}, 32'd0);
    wr(12'h210, 32'h1);
    chk("R11 irq after enable", {31'd0, irq}, 32'd1);
    rd(12'h20C, v); chk("R8 mask after enable", v, 32'hFFFF_FFFE);
    rd(12'h210, v); chk("R8 enable reads zero", v, 32'h0);
    wr(12'h218, 32'h0);
    rd(12'h218, v); chk("R9 write zero keeps", v, 32'h1);
    wr(12'h218, 32'h1);
    rd(12'h218, v); chk("R9 write one clears", v, 32'h0);
    chk("R11 irq after clear", {31'd0, irq}, 32'd0);

    // R10 rising edge
    wr(12'h220, 32'h1);
    pin_in[0] = 1; cyc(4);
    rd(12'h218, v); chk("R10 rising edge status", v, 32'h1);
    wr(12'h218, 32'h1);
    pin_in[0] = 0; cyc(4);
    rd(12'h218, v); chk("R10 rising ignores fall", v, 32'h0);

    // R10 any edge
    wr(12'h220, 32'h0);
    wr(12'h224, 32'h1);
    pin_in[0] = 1; cyc(4);
    rd(12'h218, v); chk("R10 any edge rise", v, 32'h1);
    wr(12'h218, 32'h1);
    pin_in[0] = 0; cyc(4);
    rd(12'h218, v); chk("R10 any edge fall", v, 32'h1);
    wr(12'h218, 32'h1);

    // R10 level high, R9 event wins over clear
    wr(12'h224, 32'h0);
    wr(12'h220, 32'h1);
    wr(12'h21C, 32'hFFFF_FFFE);
    pin_in[0] = 1; cyc(4);
    wr(12'h218, 32'h1);
    rd(12'h218, v); chk("R9 R10 level persists over clear", v, 32'h1);
    chk("R11 irq level", {31'd0, irq}, 32'd1);
    pin_in[0] = 0; cyc(4);
    wr(12'h218, 32'h1);
    rd(12'h218, v); chk("R10 level gone", v, 32'h0);

    // R10 level low
    wr(12'h220, 32'h0);
    cyc(1);
    rd(12'h218, v); chk("R10 level low status", v, 32'h1);

    // R8 disable
    wr(12'h214, 32'h1);
    rd(12'h20C, v); chk("R8 mask after disable", v, 32'hFFFF_FFFF);
    rd(12'h214, v); chk("R8 disable reads zero", v, 32'h0);
    chk("R11 irq masked again", {31'd0, irq}, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule